// File: doc/BRIEF.md
# Weight-Checked Five-Wire Digit Register

This block is one holding stage for a single decimal digit carried on five wires. A digit is valid when exactly two of the five wires are high, and the all-zero word means "no data". The stage needs no separate request line, because a word becomes valid only when its second wire rises. It works from a clock: every decision is taken at a rising edge from the current input, the downstream acknowledge and its own held word.

While the downstream side is not acknowledging, the stage passes its input straight to its output, one register later. When a complete two-hot word arrives it raises its upstream acknowledge. After the downstream side acknowledges, the stage holds that word until the input has gone back to all-zero. It then clears its output, and one clock later drops the upstream acknowledge.

A word with one wire high is a partial word seen on the way in or out. It is never acknowledged and never flagged as a digit. A word with three or more wires high is illegal and raises an error flag. The held word is also decoded to a digit number 0 to 9, with the ten two-hot patterns taken in ascending binary order.

Top module: `cw_digit_stage`

## Requirements
- R1: While reset is asserted, and until the first clock after the synchronised release, the output word, the upstream acknowledge, the error flag and the digit-valid flag are all 0.
- R2: While the downstream acknowledge is low, the output word at each rising edge takes the input word present before that edge, partial words included.
- R3: When the downstream acknowledge is low and the input has exactly two bits set, the upstream acknowledge is high after the next rising edge.
- R4: An input with exactly one bit set never raises a low upstream acknowledge. An output word with one bit set gives a digit-valid flag of 0.
- R5: While the downstream acknowledge is high and the input is not all-zero, the output word does not change.
- R6: When the downstream acknowledge is high, the output holds a two-hot word and the input is all-zero, the output is all-zero after the next rising edge. The upstream acknowledge stays high at that edge.
- R7: The upstream acknowledge falls only at an edge where the output word and the input word were both all-zero. It therefore falls one clock after the output is cleared.
- R8: The digit output gives the rank of the held two-hot word among the ten two-hot 5-bit patterns in ascending order (00011 is 0, 00101 is 1, and so on up to 11000, which is 9). The digit-valid flag is high exactly when the held word is two-hot.
- R9: After each rising edge the error flag is 1 when the input before that edge had three or more bits set, and 0 otherwise. Such an input never raises a low upstream acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| din | input | 5 | Incoming five-wire word |
| ack_up_o | output | 1 | Acknowledge returned to the upstream driver |
| dout | output | 5 | Held or passed-through five-wire word |
| ack_dn_i | input | 1 | Acknowledge from the downstream receiver |
| dig_o | output | 4 | Rank of the held two-hot word (0 to 9) |
| dig_vld_o | output | 1 | Held word is two-hot |
| err_o | output | 1 | Previous input had three or more bits set |

## Verification
The assertions assume that the upstream side follows the four-phase order. It changes the input only one bit at a time between all-zero and a two-hot word, and it keeps a digit steady until it sees the acknowledge. They also assume that the downstream acknowledge rises only while a digit is held. The stimulus steps the input through one-hot intermediate words on the way up and on the way down, and it raises the downstream acknowledge only after the upstream acknowledge is seen. Illegal words are applied only while the downstream acknowledge is low, and the input returns to all-zero before the next digit.

// File: rtl/cw_pkg.sv
package cw_pkg;

  localparam int unsigned CW_N = 5;
  localparam int unsigned CW_K = 2;

  function automatic int unsigned binom(input int unsigned n, input int unsigned k);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < k; i++) begin
      r = r * (n - i) / (i + 1);
    end
    return r;
  endfunction

  localparam int unsigned CW_CNT = binom(CW_N, CW_K);
  localparam int unsigned DIG_W  = $clog2(CW_CNT);

  typedef enum logic [1:0] {
    CLS_NULL  = 2'd0,
    CLS_PART  = 2'd1,
    CLS_VALID = 2'd2,
    CLS_OVER  = 2'd3
  } cw_cls_e;

endpackage

// File: rtl/cw_classify.sv
module cw_classify
  import cw_pkg::*;
#(
  parameter int unsigned N = CW_N,
  parameter int unsigned K = CW_K
) (
  input  logic [N-1:0] word_i,
  output cw_cls_e      cls_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int unsigned i = 0; i < N; i++) begin
      ones = ones + CNT_W'(word_i[i]);
    end
  end

  always_comb begin
    if (ones == '0)                 cls_o = CLS_NULL;
    else if (ones < CNT_W'(K))      cls_o = CLS_PART;
    else if (ones == CNT_W'(K))     cls_o = CLS_VALID;
    else                            cls_o = CLS_OVER;
  end

endmodule

// File: rtl/cw_digit_dec.sv
module cw_digit_dec
  import cw_pkg::*;
#(
  parameter int unsigned N  = CW_N,
  parameter int unsigned K  = CW_K,
  parameter int unsigned DW = DIG_W
) (
  input  logic [N-1:0]  word_i,
  output logic [DW-1:0] dig_o
);
  localparam int unsigned PATS = 1 << N;

  // rank = number of weight-K patterns strictly below word_i
  always_comb begin
    dig_o = '0;
    for (int unsigned p = 0; p < PATS; p++) begin
      if ((p < 32'(word_i)) && ($countones(N'(p)) == K)) begin
        dig_o = dig_o + DW'(1);
      end
    end
  end

endmodule

// File: rtl/cw_hold_stage.sv
module cw_hold_stage
  import cw_pkg::*;
#(
  parameter int unsigned N = CW_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  cw_cls_e      din_cls,
  input  cw_cls_e      out_cls,
  input  logic         ack_dn_i,
  output logic [N-1:0] dout,
  output logic         ack_up_o,
  output logic         err_o
);
  logic [N-1:0] dout_q, dout_d;
  logic         ack_q, ack_d;
  logic         err_q, err_d;
  logic         dout_en;

  // next-state logic
  always_comb begin
    dout_en = 1'b0;
    dout_d  = dout_q;
    if (!ack_dn_i) begin
      dout_en = 1'b1;
      dout_d  = din;
    end else if ((din_cls == CLS_NULL) && (out_cls == CLS_VALID)) begin
      dout_en = 1'b1;
      dout_d  = '0;
    end
  end

  always_comb begin
    if (!ack_dn_i && (din_cls == CLS_VALID))
      ack_d = 1'b1;
    else if ((out_cls == CLS_NULL) && (din_cls == CLS_NULL))
      ack_d = 1'b0;
    else
      ack_d = ack_q;
  end

  assign err_d = (din_cls == CLS_OVER);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
    end
  end

  assign dout     = dout_q;
  assign ack_up_o = ack_q;
  assign err_o    = err_q;

  // R2
  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_dn_i |=> dout == $past(din));
  // R3
  a_r3_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_dn_i && din_cls == CLS_VALID) |=> ack_up_o);
  // R4
  a_r4_part_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_up_o && din_cls == CLS_PART) |=> !ack_up_o);
  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_dn_i && din_cls != CLS_NULL) |=> $stable(dout));
  // R6
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_dn_i && din_cls == CLS_NULL && out_cls == CLS_VALID) |=> (dout == '0 && ack_up_o));
  // R7
  a_r7_ack_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_up_o && !(out_cls == CLS_NULL && din_cls == CLS_NULL)) |=> ack_up_o);
  // R9
  a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (din_cls == CLS_OVER) |=> err_o);
  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (din_cls != CLS_OVER) |=> !err_o);
  a_r9_over_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_up_o && din_cls == CLS_OVER) |=> !ack_up_o);

endmodule

// File: rtl/cw_digit_stage.sv
module cw_digit_stage
  import cw_pkg::*;
#(
  parameter int unsigned N        = CW_N,
  parameter int unsigned K        = CW_K,
  parameter int unsigned DW       = DIG_W,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  din,
  output logic          ack_up_o,
  output logic [N-1:0]  dout,
  input  logic          ack_dn_i,
  output logic [DW-1:0] dig_o,
  output logic          dig_vld_o,
  output logic          err_o
);
  localparam int unsigned CNT = binom(N, K);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  cw_cls_e             din_cls, out_cls;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  cw_classify #(.N(N), .K(K)) u_cls_in  (.word_i(din),  .cls_o(din_cls));
  cw_classify #(.N(N), .K(K)) u_cls_out (.word_i(dout), .cls_o(out_cls));

  cw_hold_stage #(.N(N)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .din      (din),
    .din_cls  (din_cls),
    .out_cls  (out_cls),
    .ack_dn_i (ack_dn_i),
    .dout     (dout),
    .ack_up_o (ack_up_o),
    .err_o    (err_o)
  );

  cw_digit_dec #(.N(N), .K(K), .DW(DW)) u_dec (.word_i(dout), .dig_o(dig_o));

  assign dig_vld_o = (out_cls == CLS_VALID);

  // R8
  a_r8_digit_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    dig_vld_o |-> (32'(dig_o) < CNT));
  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (dout == '0 && !ack_up_o && !err_o));

endmodule

// File: tb/sim_cw_digit_stage.sv
`timescale 1ns/1ps
module sim_cw_digit_stage;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] din;
  logic       ack_dn;
  logic       ack_up;
  logic [4:0] dout;
  logic [3:0] dig;
  logic       dig_vld;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cw_digit_stage u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .ack_up_o(ack_up), .dout(dout),
    .ack_dn_i(ack_dn), .dig_o(dig), .dig_vld_o(dig_vld), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply at a falling edge, wait for one rising edge, return at the next falling edge
  task automatic step(input logic [4:0] d, input logic a);
    din = d; ack_dn = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; din = 5'b00000; ack_dn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dout", dout, 0);
    chk("R1 ack", ack_up, 0);
    chk("R1 err", err, 0);
    chk("R1 vld", dig_vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dout after release", dout, 0);
  endtask

  task automatic t_handshake(input logic [4:0] pat, input int rank);
    logic [4:0] lo;
    lo = pat & ~(pat - 5'd1);
    step(lo, 1'b0);
    chk("R2 partial passes", dout, lo);
    chk("R4 partial no ack", ack_up, 0);
    chk("R4 partial not digit", dig_vld, 0);
    step(pat, 1'b0);
    chk("R2 valid passes", dout, pat);
    chk("R3 ack raised", ack_up, 1);
    chk("R8 digit", dig, rank);
    chk("R8 valid", dig_vld, 1);
    step(pat, 1'b1);
    step(pat & ~lo, 1'b1);
    chk("R5 hold partial in", dout, pat);
    chk("R7 ack held", ack_up, 1);
    step(5'b00000, 1'b1);
    chk("R6 cleared", dout, 0);
    chk("R6 ack still high", ack_up, 1);
    step(5'b00000, 1'b1);
    chk("R7 ack fell", ack_up, 0);
    step(5'b00000, 1'b0);
  endtask

  task automatic t_hold_new_word();
    step(5'b00011, 1'b0);
    step(5'b00011, 1'b1);
    step(5'b10100, 1'b1);
    chk("R5 hold other word", dout, 5'b00011);
    step(5'b00000, 1'b1);
    step(5'b00000, 1'b1);
    chk("R7 ack fell", ack_up, 0);
    step(5'b00000, 1'b0);
  endtask

  task automatic t_error();
    step(5'b00111, 1'b0);
    chk("R9 err weight3", err, 1);
    chk("R9 no ack", ack_up, 0);
    chk("R8 not digit", dig_vld, 0);
    step(5'b11111, 1'b0);
    chk("R9 err weight5", err, 1);
    step(5'b00000, 1'b0);
    chk("R9 err cleared", err, 0);
  endtask

  initial begin
    int rank;
    t_reset();
    rank = 0;
    for (int p = 0; p < 32; p++) begin
      if ($countones(5'(p)) == 2) begin
        t_handshake(5'(p), rank);
        rank++;
      end
    end
    t_hold_new_word();
    t_error();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule